// File: doc/BRIEF.md
# Phase-Domain Phase Detector for an All-Digital PLL

This block produces the phase error of an all-digital frequency synthesizer. All of it runs on the oscillator clock. A variable-phase accumulator adds one whole unit on every oscillator clock. The reference input is asynchronous, so it is retimed into the oscillator domain. Each retimed rising edge adds the frequency control word to a reference-phase accumulator. Both phases are kept as synchronous fixed-point numbers, so a plain subtraction compares them.

On each retimed reference edge the block registers three terms and flags the result with a one-cycle valid pulse:
- the reference phase,
- minus the variable phase,
- minus a fractional correction that a time-to-digital measurement supplies.

The correction stands for the sub-period quantization left by retiming, which lies between zero and one oscillator period. The control word sets the ratio of the oscillator frequency to the reference frequency. It has 8 integer bits and 16 fractional bits; a 2.4 GHz oscillator against a 13 MHz reference needs a word near 184.6. Both accumulators wrap modulo 2^28, so the difference stays correct across overflow. A loop filter downstream consumes the error.

Top module: `phase_domain_detector`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears both accumulators, `err_out` and `err_valid`.
- R2: The variable phase grows by exactly 1.0 (0x10000 in the 12.16 phase format) on every clock. With a zero control word and zero correction, two consecutive reported errors N clocks apart therefore differ by -N·0x10000 modulo 2^28.
- R3: A rising edge of `ref_in` is a low sample at one clock edge followed by a high sample at the next. If `ref_in` is first sampled high at edge n, `err_valid` is high for exactly the one cycle after edge n+2. Falling edges and steady levels of `ref_in` produce no pulse.
- R4: The reference phase adds the control word, zero-extended (bits 23:16 integer, 15:0 fraction), at each retimed reference edge and is unchanged at every other edge.
- R5: At the retimed reference edge, `err_out` becomes (reference phase − variable phase − `frac_corr`) modulo 2^28. The two phases are taken after their updates at that same edge. `frac_corr` is an unsigned fraction in bits 15:0 of the phase format. The result reads as two's complement with 12 integer and 16 fraction bits.
- R6: The error stays correct when either accumulator wraps past 2^28, including when the two wrap at different times.
- R7: Between retimed reference edges `err_out` holds its value, and changes of `frac_corr` have no effect on it.
- R8: `fcw` is used only at the edge where a retimed reference edge is taken; values it holds at other edges do not affect any later error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous frequency reference |
| fcw | input | 24 | Frequency control word, unsigned 8.16 fixed point |
| frac_corr | input | 16 | Fractional retiming correction, unsigned 0.16 |
| err_out | output | 28 | Phase error, two's complement 12.16 |
| err_valid | output | 1 | One-cycle pulse when err_out is updated |

## Verification
The hardest case to reach is the one where the two accumulators wrap at different moments, so the raw difference crosses the 2^28 boundary while the true phase error stays small. With a realistic control word the variable phase wraps only every 4096 clocks and the reference phase seldom does. The stimulus therefore uses the largest control word with a short reference period. That makes the reference phase wrap about every sixteen edges, while thousands of clocks pass so the variable phase wraps as well. Stretches of random correction and control-word changes placed between reference edges then show that only the values present at the retimed edge reach the error.

// File: rtl/pdd_pkg.sv
package pdd_pkg;

    // Fixed-point formats shared by the detector
    parameter int FCW_INT_W  = 8;
    parameter int FRAC_W     = 16;
    parameter int PH_INT_W   = 12;
    parameter int SYNC_DEPTH = 2;

    localparam int FCW_W = FCW_INT_W + FRAC_W;
    localparam int PH_W  = PH_INT_W + FRAC_W;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [FCW_W-1:0]  fcw_t;
    typedef logic [FRAC_W-1:0] frac_t;

    // One whole oscillator period in phase units
    localparam phase_t PH_UNIT = phase_t'(1) << FRAC_W;

    typedef struct packed {
        logic   valid;
        phase_t value;
    } perr_t;

    function automatic phase_t fcw_to_phase(input fcw_t w);
        return phase_t'(w);
    endfunction

    function automatic phase_t frac_to_phase(input frac_t f);
        return phase_t'(f);
    endfunction

endpackage

// File: rtl/pdd_retime.sv
module pdd_retime #(
    parameter int DEPTH = pdd_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_stb
);

    logic [DEPTH-1:0] stage_q;
    logic             last_q;

    // Synchronizer chain, then one extra flop for the edge detector
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            last_q  <= 1'b0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], async_in};
            last_q  <= stage_q[DEPTH-1];
        end
    end

    assign edge_stb = stage_q[DEPTH-1] & ~last_q;

endmodule

// File: rtl/pdd_accum.sv
module pdd_accum #(
    parameter int W      = pdd_pkg::PH_W,
    parameter int STEP_W = pdd_pkg::PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      acc_q,
    output logic [W-1:0]      acc_d
);

    // Modulo-2^W accumulation; the wrap is intentional
    assign acc_d = en ? (acc_q + W'(step)) : acc_q;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

endmodule

// File: rtl/pdd_err_stage.sv
module pdd_err_stage
    import pdd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  phase_t ref_ph,
    input  phase_t var_ph,
    input  frac_t  corr,
    output perr_t  err_q
);

    phase_t diff;

    assign diff = ref_ph - var_ph - frac_to_phase(corr);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.valid <= take;
            if (take) err_q.value <= diff;
        end
    end

endmodule

// File: rtl/phase_domain_detector.sv
module phase_domain_detector
    import pdd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic [FCW_W-1:0]  fcw,
    input  logic [FRAC_W-1:0] frac_corr,
    output logic [PH_W-1:0]   err_out,
    output logic              err_valid
);

    logic   ref_stb;
    phase_t ref_acc, ref_nxt;
    phase_t var_acc, var_nxt;
    perr_t  err_r;

    pdd_retime #(.DEPTH(SYNC_DEPTH)) u_retime (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_in),
        .edge_stb (ref_stb)
    );

    // Variable phase: one unit per oscillator clock
    pdd_accum #(.W(PH_W), .STEP_W(PH_W)) u_var_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (1'b1),
        .step  (PH_UNIT),
        .acc_q (var_acc),
        .acc_d (var_nxt)
    );

    // Reference phase: control word per retimed reference edge
    pdd_accum #(.W(PH_W), .STEP_W(FCW_W)) u_ref_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (ref_stb),
        .step  (fcw),
        .acc_q (ref_acc),
        .acc_d (ref_nxt)
    );

    pdd_err_stage u_err (
        .clk    (clk),
        .rst    (rst),
        .take   (ref_stb),
        .ref_ph (ref_nxt),
        .var_ph (var_nxt),
        .corr   (frac_corr),
        .err_q  (err_r)
    );

    assign err_out   = err_r.value;
    assign err_valid = err_r.valid;

endmodule

// File: rtl/pdd_checker.sv
module pdd_checker
    import pdd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ref_stb,
    input logic [FCW_W-1:0]  fcw,
    input logic [PH_W-1:0]   ref_acc,
    input logic [PH_W-1:0]   var_acc,
    input logic [PH_W-1:0]   err_out,
    input logic              err_valid
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!err_valid && err_out == '0 && var_acc == '0 && ref_acc == '0));

    a_r2_var_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> var_acc == PH_W'($past(var_acc) + PH_UNIT));

    a_r4_ref_step: assert property (@(posedge clk) disable iff (rst)
        ref_stb |=> ref_acc == PH_W'($past(ref_acc) + fcw_to_phase($past(fcw))));

    a_r4_ref_hold: assert property (@(posedge clk) disable iff (rst)
        !ref_stb |=> $stable(ref_acc));

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
        ref_stb |=> err_valid);

    a_r3_valid_only: assert property (@(posedge clk) disable iff (rst)
        !ref_stb |=> !err_valid);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
        !ref_stb |=> $stable(err_out));

endmodule

bind phase_domain_detector pdd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_stb   (ref_stb),
    .fcw       (fcw),
    .ref_acc   (ref_acc),
    .var_acc   (var_acc),
    .err_out   (err_out),
    .err_valid (err_valid)
);

// File: tb/sim_phase_domain_detector.sv
`timescale 1ns/1ps
module sim_phase_domain_detector;
    import pdd_pkg::*;

    localparam longint MASK = (64'sd1 <<< PH_W) - 1;
    localparam longint ONE  = 64'sd1 <<< FRAC_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_in = 1'b0;
    logic [FCW_W-1:0]  fcw = '0;
    logic [FRAC_W-1:0] frac_corr = '0;
    logic [PH_W-1:0]   err_out;
    logic              err_valid;

    always #4 clk = ~clk;

    phase_domain_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .ref_in    (ref_in),
        .fcw       (fcw),
        .frac_corr (frac_corr),
        .err_out   (err_out),
        .err_valid (err_valid)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    chk_on   = 1'b0;
    bit    done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge
    longint m_var = 0, m_ref = 0, m_err = 0;
    bit     m_val = 0;
    bit     h1 = 0, h2 = 0, h3 = 0;
    bit     m_stb;

    always @(posedge clk) begin
        if (rst) begin
            m_var = 0; m_ref = 0; m_err = 0; m_val = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            m_stb = h2 && !h3;
            h3 = h2; h2 = h1; h1 = ref_in;
            m_var = (m_var + ONE) & MASK;
            if (m_stb) begin
                m_ref = (m_ref + longint'(fcw)) & MASK;
                m_err = (m_ref - m_var - longint'(frac_corr)) & MASK;
                m_val = 1;
            end else begin
                m_val = 0;
            end
        end
    end

    // Compare on every clock, away from the active edge
    longint last_err = 0, prev_err = 0;
    int     n_valid  = 0;

    always @(negedge clk) begin
        if (chk_on) begin
            check(err_valid == m_val, cur_req, "err_valid",
                  longint'(err_valid), longint'(m_val));
            check(longint'(err_out) == m_err, cur_req, "err_out",
                  longint'(err_out), m_err);
            if (err_valid) begin
                prev_err = last_err;
                last_err = longint'(err_out);
                n_valid++;
            end
        end
    end

    task automatic pulse(input int hi, input int lo);
        ref_in = 1'b1;
        repeat (hi) @(negedge clk);
        ref_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base;
        // R1: reset, with reference activity during reset
        @(negedge clk);
        ref_in = 1'b1; fcw = 24'h123456; frac_corr = 16'h8000;
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        check(err_valid == 1'b0 && err_out == '0, "R1", "reset outputs",
              longint'(err_out), 0);
        ref_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(err_valid == 1'b0 && err_out == '0, "R1", "after release",
              longint'(err_out), 0);

        // R2: zero control word, fixed period of 10 clocks
        cur_req = "R2"; fcw = '0; frac_corr = '0;
        for (int k = 0; k < 8; k++) pulse(5, 5);
        repeat (4) @(negedge clk);
        check(((last_err - prev_err) & MASK) == ((-(10 * ONE)) & MASK), "R2",
              "error step", (last_err - prev_err) & MASK, (-(10 * ONE)) & MASK);

        // R4: control word 3.0 with a 3-clock period keeps the error constant
        cur_req = "R4"; fcw = 24'h030000;
        for (int k = 0; k < 10; k++) pulse(1, 2);
        repeat (4) @(negedge clk);
        check(last_err == prev_err, "R4", "constant error", last_err, prev_err);

        // R5: realistic ratio near 184.6 with random correction per edge
        cur_req = "R5"; fcw = 24'hB89D71;
        for (int k = 0; k < 30; k++) begin
            frac_corr = FRAC_W'($urandom);
            pulse(90, (k % 2 == 0) ? 94 : 95);
        end

        // R7 and R8: change correction and control word between edges
        for (int k = 0; k < 30; k++) begin
            cur_req = "R7";
            pulse(3, 40);
            frac_corr = FRAC_W'($urandom);
            cur_req = "R8";
            fcw = FCW_W'($urandom);
            repeat (40) @(negedge clk);
        end

        // R6: largest control word, short period, both accumulators wrap
        cur_req = "R6"; fcw = '1;
        for (int k = 0; k < 300; k++) begin
            frac_corr = FRAC_W'($urandom);
            pulse(10, 10);
        end

        // R3: narrow pulses and gaps; one valid per rising edge
        cur_req = "R3"; fcw = 24'h0A8000;
        repeat (5) @(negedge clk);
        base = n_valid;
        for (int k = 0; k < 20; k++) pulse(1, 1);
        for (int k = 0; k < 20; k++) pulse(1, 3);
        for (int k = 0; k < 20; k++) pulse(7, 2);
        repeat (6) @(negedge clk);
        check(n_valid - base == 60, "R3", "valid count",
              longint'(n_valid - base), 60);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule